// File: doc/BRIEF.md
# TDM Serial Input Framer and Deserializer

This block sits at the receive edge of a time-division switch. It runs on the 4.096 MHz timing clock and takes an active-low frame pulse. From these it keeps a frame position counter: a frame has 32 channels of 8 bits on eight 2.048 Mbit/s serial inputs, so each bit cell spans two clock cycles and one frame spans 512 cycles. Each input bit is taken once per cell, in the second cycle of that cell, and is shifted into a per-stream byte register with the most significant bit first.

When the last bit of a channel has been taken, the block copies the eight completed bytes into a holding bank. It then presents them to an external data-memory write port, one stream per cycle. The write address is the stream number joined with the channel number. The channel number, the bit number and a frame-start strobe are also brought out, so that a transmit path can align to the same frame.

Memory writes stay off until the first frame pulse after reset. A later pulse that arrives off the expected boundary pulls the counter back to the frame start.

Top module: `tdm_rx_framer`

## Requirements
- R1: Each bit cell lasts two clock cycles. The bit number output counts 7 down to 0 within a channel. The channel output advances by one every 16 cycles.
- R2: When the frame pulse input is sampled low at a rising clock edge, the next cycle is the first cycle of channel 0, bit 7. This holds from any position in the frame.
- R3: With no frame pulse, the cycle after the second cycle of channel 31 bit 0 is the first cycle of channel 0 bit 7, so a frame is 512 cycles long.
- R4: Once the block is synchronised, the frame-start output is high in exactly the first cycle of channel 0 bit 7, and low at all other times.
- R5: A serial input is sampled only at the clock edge that ends the second cycle of its cell. The value during the first cycle has no effect. The first bit received in a channel becomes bit 7 of the stored byte.
- R6: After the edge that takes a channel's bit 0, the write enable is high for exactly 8 consecutive cycles. The streams go out in ascending order 0..7. The address is {stream[2:0], channel[4:0]} (stream in bits 7:5, channel in bits 4:0), and the data is that stream's byte for that channel.
- R7: After reset and before the first frame pulse, there is no write enable and no frame-start strobe.
- R8: An active-low asynchronous reset puts the position at channel 0 bit 7, first cycle. It also clears the write enable, the frame-start output and the synchronised state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4.096 MHz timing clock, twice the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_n_i | input | 1 | Frame alignment pulse, active low |
| ser_i | input | 8 | One serial input bit per stream |
| chan_o | output | 5 | Current channel number |
| bitnum_o | output | 3 | Current bit number within the channel, 7 first |
| frame_start_o | output | 1 | High in the first cycle of each frame once synchronised |
| dm_we_o | output | 1 | Data-memory write enable |
| dm_addr_o | output | 8 | Write address {stream, channel} |
| dm_wdata_o | output | 8 | Write data byte |

## Verification
On every cycle, the embedded properties check these counter rules:
- a bit cell holds its position for exactly two cycles;
- a low frame pulse forces the frame start, and the channel-31 wrap occurs;
- the frame-start strobe appears only at that position;
- the shift registers take the newest bit at the bottom;
- each write burst starts at stream 0, rises by one and stops after stream 7;
- nothing is written before synchronisation.

Some behaviour can only be shown by the bench scenarios, which compare the ports with a behavioural model. That covers:
- whether the bytes written are the values actually on the wires;
- whether the first-half cell value is ignored (the bench drives an inverted bit there);
- what happens when a realignment pulse lands during a burst;
- whether a mid-run reset leaves the block clean.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    // Default frame geometry: streams, channels per frame, bits per channel.
    localparam int unsigned DEF_STREAMS  = 8;
    localparam int unsigned DEF_CHANNELS = 32;
    localparam int unsigned DEF_BITS     = 8;

    // Clock cycles per bit cell (timing clock at twice the bit rate).
    localparam int unsigned CYCLES_PER_CELL = 2;

    // Width of an index over n items, never below one bit.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_rx_pkg::*;
#(
    parameter  int unsigned CHANNELS = DEF_CHANNELS,
    parameter  int unsigned BITS     = DEF_BITS,
    localparam int unsigned CH_W     = idx_w(CHANNELS),
    localparam int unsigned BIT_W    = idx_w(BITS),
    localparam int unsigned SLOT_W   = CH_W + BIT_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             frame_n_i,
    output logic [CH_W-1:0]  chan_o,
    output logic [BIT_W-1:0] bitnum_o,
    output logic             sample_o,
    output logic             last_bit_o,
    output logic             frame_start_o,
    output logic             synced_o
);

    // slot layout: {channel, bit index (0 = MSB), half-cell}
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              synced;
    } timer_t;

    timer_t q, d;

    always_comb begin
        d = q;
        if (!frame_n_i) begin
            d.slot   = '0;
            d.synced = 1'b1;
        end else begin
            d.slot = q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign chan_o        = q.slot[SLOT_W-1:BIT_W+1];
    assign bitnum_o      = ~q.slot[BIT_W:1];
    assign sample_o      = q.slot[0];
    assign last_bit_o    = q.slot[0] & (&q.slot[BIT_W:1]);
    assign synced_o      = q.synced;
    assign frame_start_o = q.synced & (q.slot == '0);

    // R2: a low frame pulse lands on the first half of channel 0, top bit
    a_r2_frame_resync : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_n_i |=> (chan_o == '0 && bitnum_o == BIT_W'(BITS-1) && !sample_o));

    // R1: a cell lasts two cycles with the position held
    a_r1_cell_two_cycles : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_n_i && !sample_o) |=> ($stable(chan_o) && $stable(bitnum_o) && sample_o));

    // R3: free-running wrap from the last channel back to channel 0
    a_r3_frame_wrap : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_n_i && last_bit_o && chan_o == CH_W'(CHANNELS-1))
        |=> (chan_o == '0 && bitnum_o == BIT_W'(BITS-1) && !sample_o));

    // R4: the frame strobe appears only at the frame's first cycle
    a_r4_strobe_position : assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_o |-> (chan_o == '0 && bitnum_o == BIT_W'(BITS-1) && !sample_o));

endmodule

// File: rtl/tdm_bit_shifter.sv
module tdm_bit_shifter
    import tdm_rx_pkg::*;
#(
    parameter int unsigned STREAMS = DEF_STREAMS,
    parameter int unsigned BITS    = DEF_BITS
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             sample_i,
    input  logic [STREAMS-1:0]               ser_i,
    output logic [STREAMS-1:0][BITS-1:0]     bytes_o
);

    typedef struct packed {
        logic [STREAMS-1:0][BITS-1:0] sh;
    } shift_t;

    shift_t q, d;
    logic [STREAMS-1:0][BITS-1:0] shifted;

    for (genvar g = 0; g < STREAMS; g++) begin : g_lane
        assign shifted[g] = {q.sh[g][BITS-2:0], ser_i[g]};

        // R5: the newest bit enters at the bottom, older bits move up
        a_r5_msb_first : assert property (@(posedge clk_i) disable iff (!rst_ni)
            sample_i |=> (bytes_o[g][BITS-1:1] == $past(bytes_o[g][BITS-2:0])));
    end

    always_comb begin
        d = q;
        for (int s = 0; s < STREAMS; s++) begin
            if (sample_i) begin
                d.sh[s] = shifted[s];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // byte value including the bit present at this edge
    assign bytes_o = shifted;

endmodule

// File: rtl/tdm_write_seq.sv
module tdm_write_seq
    import tdm_rx_pkg::*;
#(
    parameter  int unsigned STREAMS  = DEF_STREAMS,
    parameter  int unsigned CHANNELS = DEF_CHANNELS,
    parameter  int unsigned BITS     = DEF_BITS,
    localparam int unsigned ST_W     = idx_w(STREAMS),
    localparam int unsigned CH_W     = idx_w(CHANNELS),
    localparam int unsigned ADDR_W   = ST_W + CH_W
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         capture_i,
    input  logic [CH_W-1:0]              chan_i,
    input  logic [STREAMS-1:0][BITS-1:0] bytes_i,
    output logic                         we_o,
    output logic [ADDR_W-1:0]            addr_o,
    output logic [BITS-1:0]              wdata_o
);

    localparam logic [ST_W-1:0] LAST_ST = ST_W'(STREAMS-1);

    typedef struct packed {
        logic                         busy;
        logic [ST_W-1:0]              idx;
        logic [CH_W-1:0]              chan;
        logic [STREAMS-1:0][BITS-1:0] hold;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        if (capture_i) begin
            d.busy = 1'b1;
            d.idx  = '0;
            d.chan = chan_i;
            d.hold = bytes_i;
        end else if (q.busy) begin
            if (q.idx == LAST_ST) begin
                d.busy = 1'b0;
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign we_o    = q.busy;
    assign addr_o  = {q.idx, q.chan};
    assign wdata_o = q.hold[q.idx];

    // R6: a burst opens at stream 0 on the captured channel
    a_r6_burst_start : assert property (@(posedge clk_i) disable iff (!rst_ni)
        capture_i |=> (we_o && addr_o[ADDR_W-1:CH_W] == '0
                       && addr_o[CH_W-1:0] == $past(chan_i)));

    // R6: streams rise by one with the channel held
    a_r6_ascending : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_o && addr_o[ADDR_W-1:CH_W] != LAST_ST && !capture_i)
        |=> (we_o && addr_o[ADDR_W-1:CH_W] == ST_W'($past(addr_o[ADDR_W-1:CH_W]) + 1'b1)
             && $stable(addr_o[CH_W-1:0])));

    // R6: the burst closes after the last stream
    a_r6_burst_end : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_o && addr_o[ADDR_W-1:CH_W] == LAST_ST && !capture_i) |=> !we_o);

endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
    import tdm_rx_pkg::*;
#(
    parameter  int unsigned STREAMS  = DEF_STREAMS,
    parameter  int unsigned CHANNELS = DEF_CHANNELS,
    parameter  int unsigned BITS     = DEF_BITS,
    localparam int unsigned ST_W     = idx_w(STREAMS),
    localparam int unsigned CH_W     = idx_w(CHANNELS),
    localparam int unsigned BIT_W    = idx_w(BITS),
    localparam int unsigned ADDR_W   = ST_W + CH_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               frame_n_i,
    input  logic [STREAMS-1:0] ser_i,
    output logic [CH_W-1:0]    chan_o,
    output logic [BIT_W-1:0]   bitnum_o,
    output logic               frame_start_o,
    output logic               dm_we_o,
    output logic [ADDR_W-1:0]  dm_addr_o,
    output logic [BITS-1:0]    dm_wdata_o
);

    logic                         sample;
    logic                         last_bit;
    logic                         synced;
    logic                         capture;
    logic [STREAMS-1:0][BITS-1:0] bytes;

    tdm_frame_timer #(
        .CHANNELS (CHANNELS),
        .BITS     (BITS)
    ) u_timer (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .frame_n_i     (frame_n_i),
        .chan_o        (chan_o),
        .bitnum_o      (bitnum_o),
        .sample_o      (sample),
        .last_bit_o    (last_bit),
        .frame_start_o (frame_start_o),
        .synced_o      (synced)
    );

    tdm_bit_shifter #(
        .STREAMS (STREAMS),
        .BITS    (BITS)
    ) u_shifter (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sample_i (sample),
        .ser_i    (ser_i),
        .bytes_o  (bytes)
    );

    assign capture = last_bit & synced;

    tdm_write_seq #(
        .STREAMS  (STREAMS),
        .CHANNELS (CHANNELS),
        .BITS     (BITS)
    ) u_writer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .capture_i (capture),
        .chan_i    (chan_o),
        .bytes_i   (bytes),
        .we_o      (dm_we_o),
        .addr_o    (dm_addr_o),
        .wdata_o   (dm_wdata_o)
    );

    // R7: nothing is written and no frame is marked before alignment
    a_r7_quiet_until_sync : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !synced |-> (!dm_we_o && !frame_start_o));

endmodule

// File: tb/tdm_rx_framer_bench.sv
module tdm_rx_framer_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fp_n;
    logic [7:0] sti;
    logic [4:0] chan;
    logic [2:0] bitnum;
    logic       fs;
    logic       we;
    logic [7:0] addr;
    logic [7:0] wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_rx_framer u_tdm_rx_framer (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .frame_n_i     (fp_n),
        .ser_i         (sti),
        .chan_o        (chan),
        .bitnum_o      (bitnum),
        .frame_start_o (fs),
        .dm_we_o       (we),
        .dm_addr_o     (addr),
        .dm_wdata_o    (wdata)
    );

    // behavioural reference state
    int         m_slot;
    bit         m_sync;
    logic [7:0] m_sh [8];
    int         exp_q [$];

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    bit    chk_en = 1'b0;
    int    fp_mode = 0;
    int    fp_slot = 0;
    int    seed = 0;
    string ph_tag = "R8";

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pat(input int s, input int ch, input int sd);
        return 8'(((s * 73) ^ (ch * 29) ^ (sd * 151)) + s + ch * sd);
    endfunction

    // reference model advances on each rising edge
    always @(posedge clk) begin
        if (rst_n) begin
            if (m_slot % 2 == 1)
                for (int s = 0; s < 8; s++) m_sh[s] = {m_sh[s][6:0], sti[s]};
            if (m_slot % 16 == 15 && m_sync)
                for (int s = 0; s < 8; s++)
                    exp_q.push_back((s * 32 + m_slot / 16) * 256 + int'(m_sh[s]));
            if (!fp_n) begin
                m_slot = 0;
                m_sync = 1'b1;
            end else begin
                m_slot = (m_slot + 1) % 512;
            end
        end
    end

    // compare on the falling edge, then drive the next cycle's inputs
    always @(negedge clk) begin
        if (rst_n && chk_en) begin
            chk({ph_tag, " R1 channel"}, int'(chan), m_slot / 16);
            chk({ph_tag, " R1 bit number"}, int'(bitnum), 7 - (m_slot / 2) % 8);
            chk("R4 frame start", int'(fs), int'(m_sync && m_slot == 0));
            chk("R6 write enable", int'(we), int'(exp_q.size() != 0));
            if (!m_sync) chk("R7 no write before sync", int'(we), 0);
            if (we && exp_q.size() != 0) begin
                int e;
                e = exp_q.pop_front();
                chk("R6 address", int'(addr), e / 256);
                chk("R5 data", int'(wdata), e % 256);
            end
        end
        for (int s = 0; s < 8; s++) begin
            logic [7:0] b;
            b = pat(s, m_slot / 16, seed);
            // first half carries the inverse: it must not be sampled (R5)
            sti[s] = (m_slot % 2 == 0) ? ~b[7 - (m_slot / 2) % 8] : b[7 - (m_slot / 2) % 8];
        end
        case (fp_mode)
            1: fp_n = (m_slot != 511);
            2: begin
                if (m_slot == fp_slot) begin
                    fp_n = 1'b0;
                    fp_mode = 0;
                end else begin
                    fp_n = 1'b1;
                end
            end
            default: fp_n = 1'b1;
        endcase
    end

    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0;
        m_slot = 0;
        m_sync = 1'b0;
        for (int s = 0; s < 8; s++) m_sh[s] = '0;
        exp_q.delete();
        repeat (n) @(negedge clk);
        chk("R8 reset channel", int'(chan), 0);
        chk("R8 reset bit number", int'(bitnum), 7);
        chk("R8 reset write enable", int'(we), 0);
        chk("R8 reset frame start", int'(fs), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        fp_n  = 1'b1;
        sti   = '0;
        m_slot = 0;
        m_sync = 1'b0;
        for (int s = 0; s < 8; s++) m_sh[s] = '0;
        chk_en = 1'b1;

        ph_tag = "R8";
        do_reset(3);

        ph_tag = "R7";
        fp_mode = 0;
        repeat (600) @(negedge clk);

        ph_tag = "R2";
        fp_slot = 200;
        fp_mode = 2;
        repeat (700) @(negedge clk);

        ph_tag = "R3";
        seed = 7;
        repeat (1100) @(negedge clk);

        ph_tag = "R1";
        fp_mode = 1;
        for (int k = 0; k < 6; k++) begin
            seed = k * 13 + 1;
            repeat (512) @(negedge clk);
        end

        // realign while a write burst is under way
        ph_tag = "R2";
        fp_slot = 18;
        fp_mode = 2;
        repeat (600) @(negedge clk);
        fp_slot = 301;
        fp_mode = 2;
        repeat (600) @(negedge clk);

        // reset in the middle of traffic
        ph_tag = "R8";
        fp_mode = 1;
        repeat (277) @(negedge clk);
        do_reset(2);
        repeat (1100) @(negedge clk);

        chk("R6 no pending writes at end", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule